// File: doc/BRIEF.md
# Serial-Loaded Control Latch

This block is a small bank of control outputs written over three slow wires that a host drives from general-purpose pins: a data wire, a shift clock and a load strobe. While the strobe is low, the host presents one bit at a time on the data wire and raises the shift clock once for each bit. Each rising edge of the shift clock pushes the bit into a hidden staging register, most significant bit first. After the last bit, the host returns the clock and data low and pulses the strobe. The rising edge of that pulse copies the staging register to the visible outputs in one step, so the outputs never show a partly shifted word.

All three wires are asynchronous to the system clock. Each wire passes through its own multi-flop synchroniser, and all edge detection is done in the system clock domain after that. The outputs start from a reset value chosen by parameter. They keep their value until the next strobe edge. The staging register resets to all zeros.

Top module: `ctl_serial_latch`

## Requirements
- R1: During and after reset, `ctl_q` equals RESET_VALUE (default 4'b1010). The staging register resets to 4'b0000, so a strobe pulse with no shifting after reset drives `ctl_q` to 4'b0000.
- R2: With the default MSB_FIRST=1, each accepted shift moves the staging bits one place toward bit 3 and enters the new bit at bit 0. After four shifts, the first bit sent appears on `ctl_q[3]` and the last on `ctl_q[0]`.
- R3: A bit is captured only on a rising edge of `ser_clk_i`. A falling edge captures nothing, and changes on `ser_data_i` while the shift clock is high or idle have no effect.
- R4: While bits are being shifted with the strobe low, `ctl_q` does not change.
- R5: A rising edge of `ser_load_i` copies the staging register to `ctl_q`. Holding the strobe high or taking it low copies nothing.
- R6: Rising edges of the shift clock while the synchronised strobe is high are ignored, and the staging register keeps its contents.
- R7: If more than four bits are shifted before a strobe pulse, only the last four remain, in order.
- R8: Without a strobe rising edge, `ctl_q` holds its value indefinitely, whatever the data and clock wires do.
- R9: If a shift-clock rising edge and a strobe rising edge are detected in the same system cycle, the strobe copies the staging value from before the shift, and the shift is dropped.
- R10: A strobe rising edge driven between system clock edges changes `ctl_q` right after the third rising system clock edge that follows it (SYNC_STAGES+1 edges), and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial data wire, asynchronous |
| ser_clk_i | input | 1 | Shift clock wire; a bit is taken on its rising edge, asynchronous |
| ser_load_i | input | 1 | Load strobe; its rising edge updates the outputs, asynchronous |
| ctl_q | output | WIDTH | Latched control outputs |

## Verification
A shift-clock rising edge and a strobe rising edge can both be detected in the same system cycle. The bench provokes this by raising both wires in one step while a known word sits in the staging register and the data wire holds a bit that would change that word. The outputs must show the word as it was before the shift. A second strobe pulse with no shifting in between must show the same word, which proves the colliding shift was dropped and not merely delayed.

// File: rtl/scl_pkg.sv
package scl_pkg;

   // Bit positions of the three host wires inside the synchroniser vector.
   localparam int SCL_LINES    = 3;
   localparam int SCL_LN_DATA  = 0;
   localparam int SCL_LN_CLK   = 1;
   localparam int SCL_LN_LOAD  = 2;

   // Per-cycle view of the synchronised wires.
   typedef struct packed {
      logic data_lvl;
      logic clk_rise;
      logic load_lvl;
      logic load_rise;
   } scl_events_t;

   function automatic scl_events_t scl_decode(input logic [SCL_LINES-1:0] lvl,
                                              input logic [SCL_LINES-1:0] rise);
      scl_events_t ev;
      ev.data_lvl  = lvl[SCL_LN_DATA];
      ev.clk_rise  = rise[SCL_LN_CLK];
      ev.load_lvl  = lvl[SCL_LN_LOAD];
      ev.load_rise = rise[SCL_LN_LOAD];
      return ev;
   endfunction

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
   parameter int LINES  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] async_i,
   output logic [LINES-1:0] level_o,
   output logic [LINES-1:0] rise_o
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("scl_sync: STAGES must be at least 2");
   end
   if (LINES < 1) begin : g_bad_lines
      $error("scl_sync: LINES must be at least 1");
   end

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      logic              prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i[g]};
            prev_q  <= chain_q[LAST];
         end
      end

      assign level_o[g] = chain_q[LAST];
      assign rise_o[g]  = chain_q[LAST] & ~prev_q;
   end

endmodule

// File: rtl/scl_shift.sv
module scl_shift #(
   parameter int              WIDTH       = 4,
   parameter bit              MSB_FIRST   = 1'b1,
   parameter logic [WIDTH-1:0] STAGE_RESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             bit_i,
   output logic [WIDTH-1:0] stage_o
);

   logic [WIDTH-1:0] stage_q;
   logic [WIDTH-1:0] stage_nx;

   if (WIDTH < 2) begin : g_bad_width
      $error("scl_shift: WIDTH must be at least 2");
   end

   if (MSB_FIRST) begin : g_msb
      assign stage_nx = {stage_q[WIDTH-2:0], bit_i};
   end else begin : g_lsb
      assign stage_nx = {bit_i, stage_q[WIDTH-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stage_q <= STAGE_RESET;
      else if (shift_en) stage_q <= stage_nx;
   end

   assign stage_o = stage_q;

endmodule

// File: rtl/scl_hold.sv
module scl_hold #(
   parameter int               WIDTH       = 4,
   parameter logic [WIDTH-1:0] RESET_VALUE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_o <= RESET_VALUE;
      else if (load_en) q_o <= d_i;
   end

endmodule

// File: rtl/ctl_serial_latch.sv
module ctl_serial_latch #(
   parameter int               WIDTH       = 4,
   parameter int               SYNC_STAGES = 2,
   parameter bit               MSB_FIRST   = 1'b1,
   parameter logic [WIDTH-1:0] RESET_VALUE = 'hA,
   parameter logic [WIDTH-1:0] STAGE_RESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_data_i,
   input  logic             ser_clk_i,
   input  logic             ser_load_i,
   output logic [WIDTH-1:0] ctl_q
);

   import scl_pkg::*;

   if (WIDTH < 2) begin : g_bad_width
      $error("ctl_serial_latch: WIDTH must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ctl_serial_latch: SYNC_STAGES must be at least 2");
   end

   logic [SCL_LINES-1:0] raw_lines;
   logic [SCL_LINES-1:0] sync_lvl;
   logic [SCL_LINES-1:0] sync_rise;
   scl_events_t          ev;

   logic             sclk_rise;
   logic             ld_rise;
   logic             ld_lvl;
   logic             shift_en;
   logic [WIDTH-1:0] stage_q;

   always_comb begin
      raw_lines               = '0;
      raw_lines[SCL_LN_DATA]  = ser_data_i;
      raw_lines[SCL_LN_CLK]   = ser_clk_i;
      raw_lines[SCL_LN_LOAD]  = ser_load_i;
   end

   scl_sync #(
      .LINES  (SCL_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw_lines),
      .level_o (sync_lvl),
      .rise_o  (sync_rise)
   );

   assign ev        = scl_decode(sync_lvl, sync_rise);
   assign sclk_rise = ev.clk_rise;
   assign ld_rise   = ev.load_rise;
   assign ld_lvl    = ev.load_lvl;
   // Shifts are accepted only while the strobe is seen low.
   assign shift_en  = sclk_rise & ~ld_lvl;

   scl_shift #(
      .WIDTH       (WIDTH),
      .MSB_FIRST   (MSB_FIRST),
      .STAGE_RESET (STAGE_RESET)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .bit_i    (ev.data_lvl),
      .stage_o  (stage_q)
   );

   scl_hold #(
      .WIDTH       (WIDTH),
      .RESET_VALUE (RESET_VALUE)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (ld_rise),
      .d_i     (stage_q),
      .q_o     (ctl_q)
   );

endmodule

// File: rtl/ctl_serial_latch_chk.sv
module ctl_serial_latch_chk #(
   parameter int WIDTH     = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] ctl_q,
   input logic             ld_rise,
   input logic             ld_lvl,
   input logic             sclk_rise,
   input logic [WIDTH-1:0] stage
);

   AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_rise |=> $stable(ctl_q)); // R8

   AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      ld_rise |=> (ctl_q == $past(stage))); // R5

   AST_STROBE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lvl |=> $stable(stage)); // R6

   AST_NO_EDGE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(stage)); // R3

   AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_rise && ld_rise) |=> (ctl_q == $past(stage)) && $stable(stage)); // R9

   if (MSB_FIRST) begin : g_msb
      AST_SHIFT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
         (sclk_rise && !ld_lvl) |=> (stage[WIDTH-1:1] == $past(stage[WIDTH-2:0]))); // R2
   end else begin : g_lsb
      AST_SHIFT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
         (sclk_rise && !ld_lvl) |=> (stage[WIDTH-2:0] == $past(stage[WIDTH-1:1]))); // R2
   end

endmodule

bind ctl_serial_latch ctl_serial_latch_chk #(
   .WIDTH     (WIDTH),
   .MSB_FIRST (MSB_FIRST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_q     (ctl_q),
   .ld_rise   (ld_rise),
   .ld_lvl    (ld_lvl),
   .sclk_rise (sclk_rise),
   .stage     (stage_q)
);

// File: tb/sim_ctl_serial_latch.sv
`timescale 1ns/1ps
module sim_ctl_serial_latch;

   localparam int         W    = 4;
   localparam logic [3:0] RV   = 4'hA;
   localparam int         GAP  = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sd = 1'b0;
   logic         sc = 1'b0;
   logic         sl = 1'b0;
   logic [W-1:0] q;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ctl_serial_latch #(.WIDTH(W), .RESET_VALUE(RV)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_data_i (sd),
      .ser_clk_i  (sc),
      .ser_load_i (sl),
      .ctl_q      (q)
   );

   task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: ctl_q=%b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bit(input logic b);
      sd = b; idle(GAP);
      sc = 1'b1; idle(GAP);
      sc = 1'b0; sd = 1'b0; idle(GAP);
   endtask

   task automatic shift_word(input logic [W-1:0] v);
      for (int i = W-1; i >= 0; i--) shift_bit(v[i]);
   endtask

   task automatic pulse_load();
      sl = 1'b1; idle(GAP);
      sl = 1'b0; idle(GAP);
   endtask

   task automatic t_reset();
      check("R1 reset value", q, RV);
      pulse_load();
      check("R1 staging resets to zero", q, 4'b0000);
   endtask

   task automatic t_basic();
      shift_word(4'b1000);
      pulse_load();
      check("R2 first bit lands on bit 3", q, 4'b1000);
      shift_word(4'b0001);
      pulse_load();
      check("R2 last bit lands on bit 0", q, 4'b0001);
      shift_word(4'b0110);
      pulse_load();
      check("R2 mixed word", q, 4'b0110);
   endtask

   task automatic t_no_partial();
      shift_word(4'b1111);
      pulse_load();
      for (int i = 0; i < W; i++) begin
         shift_bit(1'b0);
         check("R4 outputs steady while shifting", q, 4'b1111);
      end
      pulse_load();
      check("R4 word after load", q, 4'b0000);
   endtask

   task automatic t_edges();
      // data flips while clock high and while idle; falling edges capture nothing
      for (int i = 0; i < W; i++) begin
         sd = 1'b1; idle(GAP);
         sc = 1'b1; idle(GAP);
         sd = 1'b0; idle(GAP);
         sc = 1'b0; idle(GAP);
         sd = 1'b1; idle(GAP);
         sd = 1'b0; idle(GAP);
      end
      pulse_load();
      check("R3 only rising edges capture", q, 4'b1111);
   endtask

   task automatic t_overflow();
      shift_bit(1'b1); shift_bit(1'b1);
      shift_bit(1'b0); shift_bit(1'b0);
      shift_bit(1'b1); shift_bit(1'b0);
      pulse_load();
      check("R7 last four bits kept", q, 4'b0010);
   endtask

   task automatic t_strobe_high();
      shift_word(4'b0101);
      sl = 1'b1; idle(GAP);
      check("R5 rising strobe copies", q, 4'b0101);
      for (int i = 0; i < 3; i++) begin
         sd = 1'b1; idle(GAP);
         sc = 1'b1; idle(GAP);
         sc = 1'b0; idle(GAP);
      end
      sd = 1'b0;
      check("R5 held strobe copies nothing", q, 4'b0101);
      sl = 1'b0; idle(GAP);
      check("R5 falling strobe copies nothing", q, 4'b0101);
      pulse_load();
      check("R6 shifts during high strobe ignored", q, 4'b0101);
   endtask

   task automatic t_hold();
      shift_word(4'b1001);
      pulse_load();
      for (int i = 0; i < 8; i++) begin
         sd = ~sd; idle(3);
         sc = ~sc; idle(3);
      end
      sc = 1'b0; sd = 1'b0; idle(20);
      check("R8 outputs hold without strobe", q, 4'b1001);
      pulse_load();
   endtask

   task automatic t_latency();
      shift_word(4'b0111);
      pulse_load();
      shift_word(4'b1100);
      @(negedge clk);
      sl = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      check("R10 no change two edges after strobe", q, 4'b0111);
      @(posedge clk); #1;
      check("R10 change after third edge", q, 4'b1100);
      idle(GAP);
      sl = 1'b0; idle(GAP);
   endtask

   task automatic t_collide();
      shift_word(4'b0011);
      sd = 1'b1; idle(GAP);
      sc = 1'b1; sl = 1'b1; idle(GAP);
      check("R9 collision loads pre-shift word", q, 4'b0011);
      sc = 1'b0; sl = 1'b0; sd = 1'b0; idle(GAP);
      pulse_load();
      check("R9 colliding shift dropped", q, 4'b0011);
   endtask

   initial begin
      idle(3);
      check("R1 value during reset", q, RV);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_basic();
      t_no_partial();
      t_edges();
      t_overflow();
      t_strobe_high();
      t_hold();
      t_latency();
      t_collide();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, ctl_q=%b expected completion", q);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule